// File: doc/BRIEF.md
# Lines-Per-Field Serial Format Encoder

This block measures the vertical size of an incoming video raster and reports it on a single data line. It watches digitized, active-low horizontal and vertical sync signals, sampled by a fast system clock, and counts the line pulses in each field. Line pulses that arrive while vertical sync is low are not counted, so the reported figure runs about three lines below the true line total of the field.

At every vertical sync falling edge the running count is captured and the counter starts again from zero. The captured value is then sent as an 11-bit unsigned word, most significant bit first, one bit per line. The first bit appears on the third horizontal sync falling edge after the vertical edge, and the last on the thirteenth. A receiver uses horizontal sync as its bit clock and vertical sync as its frame marker, and samples near mid-line. Outside the 11-line window the data line carries no information and is held low.

Top module: `lineFieldEncoder`

## Requirements
- R1: Each horizontal sync falling edge seen while vertical sync is high adds one to an 11-bit unsigned line count (a 263-line field reports 260).
- R2: Horizontal sync falling edges while vertical sync is low are not counted (a 525-line progressive field reports 522).
- R3: The line count saturates at 2047 instead of wrapping (a 2100-line field reports 2047).
- R4: On a vertical sync falling edge the count is captured for sending and the counter restarts from zero, so each field reports only its own lines.
- R5: The captured word is sent on the data line MSB first: bit 10 after the 3rd horizontal sync falling edge following the vertical edge, bit 0 after the 13th.
- R6: The data line changes only just after a horizontal sync falling edge (or a vertical sync falling edge) and holds steady for the rest of the line.
- R7: Outside the 11-bit window (1st and 2nd edge after the vertical edge, from the 14th edge on, and from the vertical edge itself) the data line is low.
- R8: After reset the data line is low and no word is sent until the first vertical sync falling edge.
- R9: A vertical sync falling edge that arrives inside a window aborts it and starts a new window carrying the newly captured count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock |
| rstN | input | 1 | Active-low asynchronous reset |
| hSyncN | input | 1 | Digitized horizontal sync, active low |
| vSyncN | input | 1 | Digitized vertical sync, active low |
| fmtData | output | 1 | Serial lines-per-field data, MSB first |

## Verification
The hardest condition to reach is counter saturation, since it needs a field of more than 2050 lines with every line shaped correctly; the stimulus runs one such directed 2100-line field using a short line period so the run stays brief. A second awkward case is a vertical edge that lands inside a running window, which the bench creates with an 8-line field whose next vertical edge cuts the word off, then checks that the following window carries the short field's count. Random field lengths between these directed fields exercise ordinary values of the word.

// File: rtl/lpf_pkg.sv
package lpf_pkg;

  // Strobes from the control to the datapath, one cycle wide each.
  typedef struct packed {
    logic countEn;  // count one line
    logic load;     // field boundary: capture count, clear counter
    logic emit;     // drive next MSB and shift
    logic quiet;    // end of window: drive data low
  } lpfStrobe_t;

endpackage

// File: rtl/lpfSync.sv
module lpfSync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncN,
  output logic syncLevel
);

  logic [SYNC_STAGES:0] chain;

  assign chain[0] = asyncN;

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : gStage
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain[i+1] <= 1'b1;
        else       chain[i+1] <= chain[i];
      end
    end
  endgenerate

  assign syncLevel = chain[SYNC_STAGES];

endmodule

// File: rtl/lpfControl.sv
module lpfControl
  import lpf_pkg::*;
#(
  parameter int WORD_W     = 11,
  parameter int LEAD_EDGES = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       hLevel,
  input  logic       vLevel,
  output lpfStrobe_t strobe
);

  localparam int PH_END = LEAD_EDGES + WORD_W;
  localparam int PH_W   = $clog2(PH_END + 1);
  localparam logic [PH_W-1:0] EMIT_LO  = PH_W'(LEAD_EDGES - 1);
  localparam logic [PH_W-1:0] EMIT_HI  = PH_W'(LEAD_EDGES + WORD_W - 2);
  localparam logic [PH_W-1:0] QUIET_AT = PH_W'(LEAD_EDGES + WORD_W - 1);
  localparam logic [PH_W-1:0] PH_LAST  = PH_W'(PH_END);

  logic            hPrev, vPrev;
  logic            hFall, vFall;
  logic            armed;
  logic [PH_W-1:0] phase;
  logic            advance;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hPrev <= 1'b1;
      vPrev <= 1'b1;
    end else begin
      hPrev <= hLevel;
      vPrev <= vLevel;
    end
  end

  assign hFall = hPrev & ~hLevel;
  assign vFall = vPrev & ~vLevel;

  assign advance = hFall & armed & ~vFall & (phase < PH_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed <= 1'b0;
      phase <= '0;
    end else if (vFall) begin
      armed <= 1'b1;
      phase <= '0;
    end else if (advance) begin
      phase <= phase + 1'b1;
    end
  end

  always_comb begin
    strobe.countEn = hFall & vLevel;
    strobe.load    = vFall;
    strobe.emit    = advance & (phase >= EMIT_LO) & (phase <= EMIT_HI);
    strobe.quiet   = advance & (phase == QUIET_AT);
  end

endmodule

// File: rtl/lpfDatapath.sv
module lpfDatapath
  import lpf_pkg::*;
#(
  parameter int WORD_W = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  lpfStrobe_t        strobe,
  output logic [WORD_W-1:0] lineCount,
  output logic [WORD_W-1:0] shiftWord,
  output logic              dataOut
);

  localparam logic [WORD_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                        lineCount <= '0;
    else if (strobe.load)                             lineCount <= '0;
    else if (strobe.countEn && lineCount != CNT_MAX)  lineCount <= lineCount + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            shiftWord <= '0;
    else if (strobe.load) shiftWord <= lineCount;
    else if (strobe.emit) shiftWord <= {shiftWord[WORD_W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             dataOut <= 1'b0;
    else if (strobe.load)  dataOut <= 1'b0;
    else if (strobe.emit)  dataOut <= shiftWord[WORD_W-1];
    else if (strobe.quiet) dataOut <= 1'b0;
  end

endmodule

// File: rtl/lineFieldEncoder.sv
module lineFieldEncoder
  import lpf_pkg::*;
#(
  parameter int WORD_W      = 11,
  parameter int LEAD_EDGES  = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic hSyncN,
  input  logic vSyncN,
  output logic fmtData
);

  logic              hLevel, vLevel;
  lpfStrobe_t        strobe;
  logic [WORD_W-1:0] lineCount;
  logic [WORD_W-1:0] shiftWord;

  lpfSync #(.SYNC_STAGES(SYNC_STAGES)) uHSync (
    .clk(clk), .rstN(rstN), .asyncN(hSyncN), .syncLevel(hLevel)
  );

  lpfSync #(.SYNC_STAGES(SYNC_STAGES)) uVSync (
    .clk(clk), .rstN(rstN), .asyncN(vSyncN), .syncLevel(vLevel)
  );

  lpfControl #(.WORD_W(WORD_W), .LEAD_EDGES(LEAD_EDGES)) uCtrl (
    .clk(clk), .rstN(rstN), .hLevel(hLevel), .vLevel(vLevel), .strobe(strobe)
  );

  lpfDatapath #(.WORD_W(WORD_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .lineCount(lineCount), .shiftWord(shiftWord), .dataOut(fmtData)
  );

endmodule

// File: rtl/lineFieldEncoderChecker.sv
module lineFieldEncoderChecker #(
  parameter int WORD_W = 11
) (
  input logic              clk,
  input logic              rstN,
  input logic              hLevel,
  input logic              vLevel,
  input logic              loadStb,
  input logic              emitStb,
  input logic [WORD_W-1:0] lineCount,
  input logic [WORD_W-1:0] shiftWord,
  input logic              fmtData
);

  localparam logic [WORD_W-1:0] CNT_MAX = '1;

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (fmtData != $past(fmtData)) |->
      (($past(hLevel, 2) && !$past(hLevel)) || ($past(vLevel, 2) && !$past(vLevel))));

  assert_restart_R4: assert property (@(posedge clk) disable iff (!rstN)
    loadStb |=> (lineCount == '0) && (shiftWord == $past(lineCount)));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rstN)
    (lineCount == CNT_MAX && !loadStb) |=> lineCount == CNT_MAX);

  assert_vgap_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!vLevel && !loadStb) |=> $stable(lineCount));

  assert_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    loadStb |=> !fmtData);

  assert_msb_R5: assert property (@(posedge clk) disable iff (!rstN)
    emitStb |=> fmtData == $past(shiftWord[WORD_W-1]));

endmodule

bind lineFieldEncoder lineFieldEncoderChecker #(.WORD_W(WORD_W)) uChecker (
  .clk(clk), .rstN(rstN), .hLevel(hLevel), .vLevel(vLevel),
  .loadStb(strobe.load), .emitStb(strobe.emit),
  .lineCount(lineCount), .shiftWord(shiftWord), .fmtData(fmtData)
);

// File: tb/sim_lineFieldEncoder.sv
`timescale 1ns/1ps
module sim_lineFieldEncoder;

  localparam int LINE_CYC = 24;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hSyncN = 1'b1;
  logic vSyncN = 1'b1;
  logic fmtData;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  // bench model state
  int  modelCnt = 0;
  int  latched = 0;
  int  edgeSinceV = 0;
  bit  armed = 1'b0;
  bit  vLow = 1'b0;
  int  vEdges = 0;
  int  word = 0;

  always #2.5 clk = ~clk;

  lineFieldEncoder u0 (
    .clk(clk), .rstN(rstN), .hSyncN(hSyncN), .vSyncN(vSyncN), .fmtData(fmtData)
  );

  task automatic check(input string tag, input int act, input int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int expectedBit();
    if (armed && edgeSinceV >= 3 && edgeSinceV <= 13)
      return (latched >> (13 - edgeSinceV)) & 1;
    return 0;
  endfunction

  function automatic int fieldWord(input int lines);
    return (lines - 3 > 2047) ? 2047 : lines - 3;
  endfunction

  task automatic runLine(input bit vStart);
    int s1;
    bit inWin;
    for (int c = 0; c < LINE_CYC; c++) begin
      @(posedge clk); #1;
      if (c == 0) begin
        hSyncN = 1'b0;
        if (vLow) vEdges++;
        else if (modelCnt < 2047) modelCnt++;
        if (armed && edgeSinceV < 20) edgeSinceV++;
      end
      if (c == 4) hSyncN = 1'b1;
      if (c == 8) begin
        s1 = int'(fmtData);
        inWin = armed && edgeSinceV >= 3 && edgeSinceV <= 13;
        check(inWin ? "R5 window bit" : "R7 idle low", s1, expectedBit());
        if (inWin) word = ((word << 1) | s1) & 32'h7FF;
      end
      if (c == 12) begin
        if (vStart) begin
          vSyncN = 1'b0; vLow = 1'b1; vEdges = 0;
          latched = modelCnt; modelCnt = 0; edgeSinceV = 0; armed = 1'b1;
          word = 0;
        end else if (vLow && vEdges == 3) begin
          vSyncN = 1'b1; vLow = 1'b0;
        end
      end
      if (c == 22) begin
        if (vStart) check("R7 low after field edge", int'(fmtData), 0);
        else        check("R6 steady within line", int'(fmtData), s1);
      end
    end
  endtask

  task automatic runField(input int lines, input int expWord, input string tag);
    for (int i = 0; i < lines; i++) runLine(i == 0);
    if (lines >= 14 && expWord >= 0) check(tag, word, expWord);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      testsFailed++;
      testsRun++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    int prevLen;
    int len;
    void'($urandom(32'd2024));
    repeat (4) @(posedge clk);
    #1;
    check("R8 reset low", int'(fmtData), 0);
    rstN = 1'b1;
    // lines before any vertical edge: no window (R8)
    for (int i = 0; i < 5; i++) runLine(1'b0);
    runField(263, 6, "R8 first word counts pre-field lines");
    runField(262, fieldWord(263), "R1 263-line field gives 260");
    runField(525, fieldWord(262), "R1 262-line field gives 259");
    runField(8, fieldWord(525), "R2 525-line field gives 522");
    runField(20, fieldWord(8), "R9 aborted window, next word is 5");
    runField(2100, fieldWord(20), "R4 counter restarted, 17");
    runField(20, 2047, "R3 saturated count");
    prevLen = 20;
    for (int k = 0; k < 6; k++) begin
      len = $urandom_range(200, 16);
      runField(len, fieldWord(prevLen), "R1 random field word");
      prevLen = len;
    end
    runField(20, fieldWord(prevLen), "R1 last random field word");
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule